// File: doc/BRIEF.md
# Serialized Register Access Channel

This block is the host side of a command channel to a power-management companion chip. Software places one 32-bit command word, and the block turns it into a single 32-bit frame on a one-bit serial link: a direction bit, a 15-bit halfword address and 16 data bits. The block reports its progress through a 32-bit status word. Software polls that word for the channel state code, a pending-request flag, a sync-idle flag, an init-done flag and the 16 bits of read data.

A write finishes by itself. A read stays parked in a wait-for-valid-clear state with its data on view until software writes a 1 to the valid-clear strobe. The chip-select framing can be stretched. The time chip-select stays low before the first clock and after the last clock can be set, and so can the time it stays high after the frame. The high-time is set separately for writes and for reads. A command that arrives while the channel is busy is dropped and sets a sticky error flag.

Top module: `sreg_chan`

## Requirements
- R1: In `cmd_word`, bit 31 selects write (1) or read (0), bits 30:16 hold the halfword address and bits 15:0 the write data. The serial frame sends the direction bit, then the address, then 16 data bits, all MSB first. The data bits are driven 0 for a read.
- R2: In `stat_word`, bits 15:0 hold read data, bits 18:16 the state code, bit 19 the pending-request flag (1 only in the request state), bit 20 sync-idle and bit 21 init-done. Bits 31:22 read 0.
- R3: The state codes are idle 0, request 2, wait-for-idle 4 and wait-for-valid-clear 6. The cycle after acceptance is request, and the cycle after that is wait-for-idle.
- R4: A finished read holds state 6, with its data stable, until a cycle with `vclr_wr` high and `vclr_bit` 1 returns it to idle on the next edge. A valid-clear with `vclr_bit` 0, or one given outside state 6, has no effect.
- R5: A finished write returns straight to idle (state 0) without any valid-clear.
- R6: Read data is sampled from `spi_miso` on each rising edge of `spi_sck` during the 16 data bits, MSB first. A write leaves the previous read data in the status word.
- R7: `spi_cs_n` stays low for `cfg_csl_lead`+1 cycles before the first serial clock. It then stays low for 64 cycles of serial clock (one low and one high cycle per bit) and for `cfg_csl_tail`+1 cycles after it. While idle, `spi_cs_n` is 1 and `spi_sck` is 0.
- R8: After chip-select rises it stays high for `cfg_csh_wr`+1 cycles (writes) or `cfg_csh_rd`+1 cycles (reads) before completion. The state therefore leaves 4 exactly lead+tail+hold+68 clock edges after the edge that accepts the command.
- R9: Sync-idle is 0 from the cycle after acceptance until the channel leaves state 4, and it is 0 whenever chip-select is low.
- R10: Writing `init_bit` with `init_wr` sets the init-done register, and status bit 21 mirrors that register.
- R11: A command given while the state is not idle is ignored: the frame in flight and any parked data are left alone. It sets `err_flag`, which stays set until reset.
- R12: After reset the status word is 0x00100000 (only sync-idle set), `err_flag` is 0, `spi_cs_n` is 1 and `spi_sck` and `spi_mosi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command-word write strobe |
| cmd_word | input | 32 | Command word (direction, halfword address, write data) |
| vclr_wr | input | 1 | Valid-clear write strobe |
| vclr_bit | input | 1 | Valid-clear data bit (1 releases a parked read) |
| init_wr | input | 1 | Init-done register write strobe |
| init_bit | input | 1 | Init-done register data |
| cfg_csh_wr | input | 4 | Extra chip-select high cycles after a write |
| cfg_csh_rd | input | 4 | Extra chip-select high cycles after a read |
| cfg_csl_lead | input | 4 | Extra chip-select low cycles before the first clock |
| cfg_csl_tail | input | 4 | Extra chip-select low cycles after the last clock |
| spi_miso | input | 1 | Serial data from the companion chip |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the companion chip |
| stat_word | output | 32 | Status word |
| err_flag | output | 1 | Sticky flag for a command given while busy |

## Verification
The state code moves to 2 on the edge that accepts a command and to 4 one edge later. It leaves 4 exactly lead+tail+hold+68 edges after acceptance. The bench works that count out from each vector's settings and samples the status two time units after the edges in question: the one just before completion and the completion edge itself. A valid-clear takes effect on the edge that samples it, so the bench checks the state one edge after it drives each strobe. A bench-side serial model counts chip-select-low cycles and captures `spi_mosi` on each `spi_sck` rise. It drives `spi_miso` while the clock is low, so the captured frame and the returned data are compared only after the completion edge.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // Channel state codes; software decodes these from the status word.
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd2,
      ST_BUSY = 3'd4,
      ST_PARK = 3'd6
   } chan_st_e;

   // Serial engine phases.
   typedef enum logic [2:0] {
      SE_IDLE,
      SE_LEAD,
      SE_BIT,
      SE_TAIL,
      SE_HOLD
   } ser_st_e;

   // Status word layout.
   localparam int STAT_FSM_LSB  = 16;
   localparam int STAT_REQ_BIT  = 19;
   localparam int STAT_SYNC_BIT = 20;
   localparam int STAT_INIT_BIT = 21;
   localparam int STAT_USED     = 22;

endpackage

// File: rtl/sreg_cmd_fsm.sv
module sreg_cmd_fsm
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 16,
   localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              vclr_wr,
   input  logic              vclr_bit,
   input  logic              eng_done,
   output chan_st_e          st,
   output logic              eng_start,
   output logic              frm_wr,
   output logic [ADDR_W-1:0] frm_addr,
   output logic [DATA_W-1:0] frm_wdata,
   output logic              err
);

   chan_st_e st_q;
   logic     wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic     err_q;

   // Command word fields.
   logic              cmd_is_wr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;

   assign cmd_is_wr = cmd_word[CMD_W-1];
   assign cmd_addr  = cmd_word[CMD_W-2 -: ADDR_W];
   assign cmd_data  = cmd_word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_wr) begin
                  st_q    <= ST_REQ;
                  wr_q    <= cmd_is_wr;
                  addr_q  <= cmd_addr;
                  wdata_q <= cmd_data;
               end
            end
            ST_REQ:  st_q <= ST_BUSY;
            ST_BUSY: begin
               if (eng_done) st_q <= wr_q ? ST_IDLE : ST_PARK;
            end
            ST_PARK: begin
               if (vclr_wr && vclr_bit) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // A command outside idle is dropped and recorded.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           err_q <= 1'b0;
      else if (cmd_wr && st_q != ST_IDLE)   err_q <= 1'b1;
   end

   assign st        = st_q;
   assign eng_start = (st_q == ST_REQ);
   assign frm_wr    = wr_q;
   assign frm_addr  = addr_q;
   assign frm_wdata = wdata_q;
   assign err       = err_q;

endmodule

// File: rtl/sreg_serial.sv
module sreg_serial
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 16,
   parameter int EXT_W  = 4,
   localparam int FRAME  = 1 + ADDR_W + DATA_W,
   localparam int BIDX_W = $clog2(FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [EXT_W-1:0]  ext_lead,
   input  logic [EXT_W-1:0]  ext_tail,
   input  logic [EXT_W-1:0]  ext_hold_wr,
   input  logic [EXT_W-1:0]  ext_hold_rd,
   input  logic              miso,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   localparam logic [BIDX_W-1:0] DATA_FIRST = BIDX_W'(FRAME - DATA_W);
   localparam logic [BIDX_W-1:0] LAST_BIT   = BIDX_W'(FRAME - 1);

   ser_st_e           st_q;
   logic [EXT_W-1:0]  cnt_q;
   logic [EXT_W-1:0]  lim_lead_q, lim_tail_q, lim_hold_q;
   logic [BIDX_W-1:0] bidx_q;
   logic              half_q;
   logic              wr_q;
   logic [FRAME-1:0]  fsh_q;
   logic [DATA_W-1:0] rsh_q;
   logic              sck_q, csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SE_IDLE;
         cnt_q      <= '0;
         lim_lead_q <= '0;
         lim_tail_q <= '0;
         lim_hold_q <= '0;
         bidx_q     <= '0;
         half_q     <= 1'b0;
         wr_q       <= 1'b0;
         fsh_q      <= '0;
         rsh_q      <= '0;
         sck_q      <= 1'b0;
         csn_q      <= 1'b1;
      end else begin
         unique case (st_q)
            SE_IDLE: begin
               if (start) begin
                  st_q       <= SE_LEAD;
                  cnt_q      <= '0;
                  csn_q      <= 1'b0;
                  wr_q       <= is_wr;
                  fsh_q      <= {is_wr, addr, (is_wr ? wdata : {DATA_W{1'b0}})};
                  lim_lead_q <= ext_lead;
                  lim_tail_q <= ext_tail;
                  lim_hold_q <= is_wr ? ext_hold_wr : ext_hold_rd;
               end
            end
            SE_LEAD: begin
               if (cnt_q == lim_lead_q) begin
                  st_q   <= SE_BIT;
                  bidx_q <= '0;
                  half_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SE_BIT: begin
               if (!half_q) begin
                  // Rising serial clock: sample the data phase of a read.
                  half_q <= 1'b1;
                  sck_q  <= 1'b1;
                  if (!wr_q && bidx_q >= DATA_FIRST)
                     rsh_q <= {rsh_q[DATA_W-2:0], miso};
               end else begin
                  half_q <= 1'b0;
                  sck_q  <= 1'b0;
                  fsh_q  <= fsh_q << 1;
                  if (bidx_q == LAST_BIT) begin
                     st_q  <= SE_TAIL;
                     cnt_q <= '0;
                  end else begin
                     bidx_q <= bidx_q + 1'b1;
                  end
               end
            end
            SE_TAIL: begin
               if (cnt_q == lim_tail_q) begin
                  st_q  <= SE_HOLD;
                  cnt_q <= '0;
                  csn_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SE_HOLD: begin
               if (cnt_q == lim_hold_q) st_q <= SE_IDLE;
               else                     cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= SE_IDLE;
         endcase
      end
   end

   assign done  = (st_q == SE_HOLD) && (cnt_q == lim_hold_q);
   assign mosi  = (st_q == SE_BIT) && fsh_q[FRAME-1];
   assign sck   = sck_q;
   assign cs_n  = csn_q;
   assign rdata = rsh_q;

endmodule

// File: rtl/sreg_status.sv
module sreg_status
   import sreg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_wr,
   input  logic              init_bit,
   input  logic [DATA_W-1:0] rdata,
   input  chan_st_e          st,
   output logic [STAT_W-1:0] stat_word
);

   logic        init_q;
   logic [15:0] dfield;
   logic        req_flag, sync_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       init_q <= 1'b0;
      else if (init_wr) init_q <= init_bit;
   end

   assign req_flag  = (st == ST_REQ);
   assign sync_idle = (st == ST_IDLE) || (st == ST_PARK);

   generate
      if (DATA_W < 16) begin : g_dpad
         assign dfield = {{(16 - DATA_W){1'b0}}, rdata};
      end else begin : g_dfull
         assign dfield = rdata;
      end
      if (STAT_W > STAT_USED) begin : g_upad
         assign stat_word[STAT_W-1:STAT_USED] = '0;
      end
   endgenerate

   assign stat_word[STAT_USED-1:0] = {init_q, sync_idle, req_flag, st, dfield};

endmodule

// File: rtl/sreg_chan.sv
module sreg_chan
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 16,
   parameter int EXT_W  = 4,
   parameter int STAT_W = 32,
   localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              vclr_wr,
   input  logic              vclr_bit,
   input  logic              init_wr,
   input  logic              init_bit,
   input  logic [EXT_W-1:0]  cfg_csh_wr,
   input  logic [EXT_W-1:0]  cfg_csh_rd,
   input  logic [EXT_W-1:0]  cfg_csl_lead,
   input  logic [EXT_W-1:0]  cfg_csl_tail,
   input  logic              spi_miso,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   output logic [STAT_W-1:0] stat_word,
   output logic              err_flag
);

   initial begin : p_param_chk
      PRM_DATA_FITS: assert (DATA_W >= 2 && DATA_W <= 16)
         else $error("DATA_W must lie in 2..16 to fit the status data field");
      PRM_STAT_FITS: assert (STAT_W >= STAT_USED)
         else $error("STAT_W too small for the status layout");
      PRM_EXT_W: assert (EXT_W >= 1)
         else $error("EXT_W must be at least 1");
   end

   chan_st_e          st;
   logic              eng_start, eng_done;
   logic              frm_wr;
   logic [ADDR_W-1:0] frm_addr;
   logic [DATA_W-1:0] frm_wdata;
   logic [DATA_W-1:0] rdata;

   sreg_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_word  (cmd_word),
      .vclr_wr   (vclr_wr),
      .vclr_bit  (vclr_bit),
      .eng_done  (eng_done),
      .st        (st),
      .eng_start (eng_start),
      .frm_wr    (frm_wr),
      .frm_addr  (frm_addr),
      .frm_wdata (frm_wdata),
      .err       (err_flag)
   );

   sreg_serial #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_W(EXT_W)) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (eng_start),
      .is_wr       (frm_wr),
      .addr        (frm_addr),
      .wdata       (frm_wdata),
      .ext_lead    (cfg_csl_lead),
      .ext_tail    (cfg_csl_tail),
      .ext_hold_wr (cfg_csh_wr),
      .ext_hold_rd (cfg_csh_rd),
      .miso        (spi_miso),
      .sck         (spi_sck),
      .cs_n        (spi_cs_n),
      .mosi        (spi_mosi),
      .rdata       (rdata),
      .done        (eng_done)
   );

   sreg_status #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_wr   (init_wr),
      .init_bit  (init_bit),
      .rdata     (rdata),
      .st        (st),
      .stat_word (stat_word)
   );

endmodule

// File: rtl/sreg_chan_chk.sv
module sreg_chan_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wr,
   input logic              cmd_dir,
   input logic              vclr_wr,
   input logic              vclr_bit,
   input logic [2:0]        st_code,
   input logic [DATA_W-1:0] rdata,
   input logic              sync_idle,
   input logic              cs_n,
   input logic              sck,
   input logic              err
);

   // Direction of the command most recently accepted.
   logic last_wr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          last_wr <= 1'b0;
      else if (cmd_wr && st_code == 3'd0)  last_wr <= cmd_dir;
   end

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'd0 || st_code == 3'd2 || st_code == 3'd4 || st_code == 3'd6)); // R3
   AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && st_code == 3'd0) |=> (st_code == 3'd2 && !sync_idle)); // R9
   AST_REQ_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'd2) |=> (st_code == 3'd4)); // R3
   AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'd6 && !(vclr_wr && vclr_bit)) |=> (st_code == 3'd6 && $stable(rdata))); // R4
   AST_PARK_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'd6 && vclr_wr && vclr_bit) |=> (st_code == 3'd0)); // R4
   AST_WRITE_NOPARK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'd4 && last_wr) |=> (st_code != 3'd6)); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R11
   AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && st_code != 3'd0) |=> err); // R11
   AST_CS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !sync_idle); // R9
   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_code == 3'd0) |-> (cs_n && !sck)); // R7

endmodule

bind sreg_chan sreg_chan_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cmd_dir   (cmd_word[CMD_W-1]),
   .vclr_wr   (vclr_wr),
   .vclr_bit  (vclr_bit),
   .st_code   (stat_word[18:16]),
   .rdata     (stat_word[DATA_W-1:0]),
   .sync_idle (stat_word[20]),
   .cs_n      (spi_cs_n),
   .sck       (spi_sck),
   .err       (err_flag)
);

// File: tb/sreg_chan_tb.sv
`timescale 1ns/100ps
module sreg_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_word = '0;
   logic        vclr_wr = 1'b0, vclr_bit = 1'b0;
   logic        init_wr = 1'b0, init_bit = 1'b0;
   logic [3:0]  cfg_csh_wr = '0, cfg_csh_rd = '0, cfg_csl_lead = '0, cfg_csl_tail = '0;
   logic        spi_miso = 1'b0;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic [31:0] stat_word;
   logic        err_flag;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   sreg_chan u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .vclr_wr(vclr_wr), .vclr_bit(vclr_bit), .init_wr(init_wr), .init_bit(init_bit),
      .cfg_csh_wr(cfg_csh_wr), .cfg_csh_rd(cfg_csh_rd),
      .cfg_csl_lead(cfg_csl_lead), .cfg_csl_tail(cfg_csl_tail),
      .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .stat_word(stat_word), .err_flag(err_flag)
   );

   // Serial slave model: counts chip-select low cycles, captures mosi on
   // each sck rise, drives miso while sck is low.
   logic [31:0] mframe = '0;
   logic [31:0] cap = '0;
   int          nrise = 0;
   int          cs_low = 0;
   logic        prev_sck = 1'b0;

   always @(posedge clk) begin
      #1;
      if (!spi_cs_n) cs_low++;
      if (spi_sck && !prev_sck) begin
         cap = {cap[30:0], spi_mosi};
         nrise++;
      end
      prev_sck = spi_sck;
      if (!spi_cs_n && !spi_sck && nrise < 32) spi_miso = mframe[31 - nrise];
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // {wr, addr15, wdata16, miso16, lead4, tail4, hold_wr4, hold_rd4}
   localparam logic [63:0] VEC [0:5] = '{
      {1'b1, 15'h5E00, 16'hA55A, 16'h0000, 4'd2,  4'd2,  4'd0,  4'd4},
      {1'b0, 15'h5E05, 16'hFFFF, 16'h5AA5, 4'd2,  4'd2,  4'd0,  4'd4},
      {1'b0, 15'h7FFF, 16'h1111, 16'h8001, 4'd0,  4'd0,  4'd3,  4'd0},
      {1'b1, 15'h0001, 16'hFFFF, 16'h0000, 4'd15, 4'd15, 4'd15, 4'd0},
      {1'b0, 15'h0000, 16'h0000, 16'hFFFF, 4'd1,  4'd3,  4'd0,  4'd15},
      {1'b1, 15'h2AAA, 16'h1234, 16'h0000, 4'd0,  4'd0,  4'd0,  4'd9}
   };

   logic [15:0] last_rd = '0;

   task automatic run_cmd(input logic [63:0] v);
      logic        wr;
      logic [14:0] addr;
      logic [15:0] wd, md;
      logic [3:0]  ls, le, hw, hr;
      int          lat;
      {wr, addr, wd, md, ls, le, hw, hr} = v;
      cfg_csl_lead = ls; cfg_csl_tail = le; cfg_csh_wr = hw; cfg_csh_rd = hr;
      mframe = {~md, md};
      lat = int'(ls) + int'(le) + int'(wr ? hw : hr) + 68;
      tick();
      cap = '0; nrise = 0; cs_low = 0;
      cmd_wr = 1'b1; cmd_word = {wr, addr, wd};
      tick();                                   // accepting edge
      cmd_wr = 1'b0;
      check("R3 request state", 32'(stat_word[18:16]), 32'd2);
      check("R2 request flag", 32'(stat_word[19]), 32'd1);
      check("R9 sync-idle low", 32'(stat_word[20]), 32'd0);
      repeat (lat - 1) @(posedge clk);
      #2;
      check("R8 still busy before completion", 32'(stat_word[18:16]), 32'd4);
      check("R9 sync-idle low while busy", 32'(stat_word[20]), 32'd0);
      tick();                                   // completion edge
      check("R9 sync-idle back", 32'(stat_word[20]), 32'd1);
      check("R1 frame", cap, {wr, addr, (wr ? wd : 16'h0000)});
      check("R1 bit count", 32'(nrise), 32'd32);
      check("R7 chip-select low cycles", 32'(cs_low), 32'(int'(ls) + int'(le) + 66));
      if (wr) begin
         check("R5 write back to idle", 32'(stat_word[18:16]), 32'd0);
         check("R6 write keeps read data", 32'(stat_word[15:0]), 32'(last_rd));
      end else begin
         check("R8 read parked on time", 32'(stat_word[18:16]), 32'd6);
         check("R6 read data", 32'(stat_word[15:0]), 32'(md));
         last_rd = md;
         vclr_wr = 1'b1; vclr_bit = 1'b0;
         tick();
         vclr_wr = 1'b0;
         check("R4 zero valid-clear ignored", 32'(stat_word[18:16]), 32'd6);
         vclr_wr = 1'b1; vclr_bit = 1'b1;
         tick();
         vclr_wr = 1'b0; vclr_bit = 1'b0;
         check("R4 valid-clear releases", 32'(stat_word[18:16]), 32'd0);
         check("R4 data kept after clear", 32'(stat_word[15:0]), 32'(md));
      end
      check("R11 no error on clean command", 32'(err_flag), 32'd0);
   endtask

   initial begin : p_watchdog
      #500000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(posedge clk);
      #2;
      check("R12 reset status", stat_word, 32'h0010_0000);
      check("R12 reset lines", {29'h0, spi_cs_n, spi_sck, spi_mosi}, 32'h4);
      check("R12 reset error", 32'(err_flag), 32'd0);
      rst_n = 1'b1;
      tick();

      // Init-done register.
      init_wr = 1'b1; init_bit = 1'b1;
      tick();
      init_wr = 1'b0;
      check("R10 init-done set", 32'(stat_word[21]), 32'd1);
      init_wr = 1'b1; init_bit = 1'b0;
      tick();
      init_wr = 1'b0;
      check("R10 init-done clear", 32'(stat_word[21]), 32'd0);
      init_wr = 1'b1; init_bit = 1'b1;
      tick();
      init_wr = 1'b0;

      // Valid-clear while idle does nothing.
      vclr_wr = 1'b1; vclr_bit = 1'b1;
      tick();
      vclr_wr = 1'b0; vclr_bit = 1'b0;
      check("R4 valid-clear in idle", stat_word, 32'h0030_0000);

      for (int i = 0; i < 6; i++) run_cmd(VEC[i]);
      check("R2 upper bits zero", 32'(stat_word[31:22]), 32'd0);

      // Command while busy and while parked.
      cfg_csl_lead = 4'd0; cfg_csl_tail = 4'd0; cfg_csh_wr = 4'd0; cfg_csh_rd = 4'd0;
      mframe = {16'h3C3C, 16'hC3C3};
      tick();
      cap = '0; nrise = 0; cs_low = 0;
      cmd_wr = 1'b1; cmd_word = {1'b0, 15'h1234, 16'h0000};
      tick();
      cmd_wr = 1'b0;
      repeat (10) tick();
      cmd_wr = 1'b1; cmd_word = {1'b1, 15'h0F0F, 16'hBEEF};
      tick();
      cmd_wr = 1'b0;
      check("R11 busy command sets error", 32'(err_flag), 32'd1);
      check("R11 busy command leaves state", 32'(stat_word[18:16]), 32'd4);
      for (int k = 0; k < 200 && stat_word[18:16] == 3'd4; k++) tick();
      check("R11 frame in flight untouched", cap, {1'b0, 15'h1234, 16'h0000});
      check("R11 read still parks", 32'(stat_word[18:16]), 32'd6);
      check("R6 read data after busy command", 32'(stat_word[15:0]), 32'hC3C3);
      cmd_wr = 1'b1; cmd_word = {1'b1, 15'h0F0F, 16'hBEEF};
      tick();
      cmd_wr = 1'b0;
      check("R11 parked command ignored", stat_word[21:0], {1'b1, 1'b1, 1'b0, 3'd6, 16'hC3C3});
      repeat (3) tick();
      check("R11 no frame started", 32'(spi_cs_n), 32'd1);
      check("R11 error sticky", 32'(err_flag), 32'd1);
      vclr_wr = 1'b1; vclr_bit = 1'b1;
      tick();
      vclr_wr = 1'b0; vclr_bit = 1'b0;
      check("R4 release after busy test", 32'(stat_word[18:16]), 32'd0);

      rst_n = 1'b0;
      tick();
      check("R12 reset clears error", 32'(err_flag), 32'd0);
      check("R12 reset clears status", stat_word, 32'h0010_0000);
      rst_n = 1'b1;
      tick();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule